// File: doc/BRIEF.md
# Four-Set Memory Page Mapper

The mapper turns a 15-bit logical word address into a 20-bit physical word address, so that a processor with a 32K-word logical space can reach up to 1024K words of memory. It holds 128 map registers of 16 bits, grouped as four sets of 32 pages: system, user, DMA port A and DMA port B. The five top bits of the logical address pick one page register in the active set. The ten low bits pass through unchanged as the word offset inside a 1K-word page.

The active set is normally the system or user set, chosen by a current-map input. An access may instead force any of the four sets. Each page register carries a 10-bit physical page number and two protection flags. A read of a read-protected page, or a write to a write-protected page, raises a one-cycle violation. The same access also records its page, set and direction in a violation register. When mapping is disabled, the physical address is the logical address with zeros on top, and no violation can occur.

Top module: `page_mapper`

## Requirements
- R1: After reset, every map register and the violation register read zero, and `viol` is low.
- R2: A write with `cfg_we` high stores `cfg_wdata` into map register `cfg_idx` at the clock edge. The index is set*32 + page, with set codes 0 system, 1 user, 2 port A and 3 port B. The new value is used for translation from the next cycle on.
- R3: With `map_en` low, `phys_addr` equals `log_addr` zero-extended to 20 bits, and `viol` stays low.
- R4: With `map_en` high, `phys_addr[19:10]` is bits 9:0 of the selected map register and `phys_addr[9:0]` is `log_addr[9:0]`. The register is selected by the active set and by `log_addr[14:10]`.
- R5: With `force_en` low, the active set is the user set when `cur_user` is 1 and the system set when it is 0.
- R6: With `force_en` high, the active set is `force_set` (0 system, 1 user, 2 port A, 3 port B), whatever the value of `cur_user`.
- R7: A read (`acc_valid` high, `acc_write` low) through an entry whose bit 15 (read-protect) is set drives `viol` high in the same cycle. A read through an entry whose bit 15 is clear leaves `viol` low.
- R8: A write (`acc_valid` and `acc_write` high) through an entry whose bit 14 (write-protect) is set drives `viol` high in the same cycle. A write through an entry whose bit 14 is clear leaves `viol` low.
- R9: On the edge that ends a violating cycle, `viol_reg` loads bit 15 = 1, bit 8 = write flag, bits 6:5 = set and bits 4:0 = logical page, with all other bits 0. The register keeps that value until the next violation.
- R10: With `acc_valid` low, `viol` stays low whatever the map contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_en | input | 1 | Translation enable |
| cur_user | input | 1 | Current map: 1 user set, 0 system set |
| force_en | input | 1 | Use `force_set` instead of the current map |
| force_set | input | 2 | Forced set: 0 sys, 1 user, 2 port A, 3 port B |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | Access is a write |
| log_addr | input | 15 | Logical word address |
| phys_addr | output | 20 | Physical word address |
| viol | output | 1 | Protection violation this cycle |
| viol_reg | output | 16 | Captured last violation |
| cfg_we | input | 1 | Map register write strobe |
| cfg_idx | input | 7 | Map register index |
| cfg_wdata | input | 16 | Map register write data |

## Verification
The assertions assume that the address and control inputs are held steady through each cycle and are known after reset. They also assume that a map write and an access to the same entry in the same cycle resolve to the old contents. The bench changes inputs only at falling edges. It loads the maps in their own cycles, before any access that depends on them. Accesses with protection bits set are made only in the dedicated protection phase, so the bypass and translation sweeps never produce a violation.

// File: rtl/pmap_pkg.sv
package pmap_pkg;
  localparam int LA_W   = 15;
  localparam int OFS_W  = 10;
  localparam int PG_W   = LA_W - OFS_W;
  localparam int PPN_W  = 10;
  localparam int PA_W   = PPN_W + OFS_W;
  localparam int ENT_W  = 16;
  localparam int SET_W  = 2;
  localparam int NSETS  = 1 << SET_W;
  localparam int IDX_W  = SET_W + PG_W;
  localparam int DEPTH  = NSETS << PG_W;
  localparam int RP_BIT = ENT_W - 1;
  localparam int WP_BIT = ENT_W - 2;

  typedef enum logic [SET_W-1:0] {
    MAP_SYS = 2'd0,
    MAP_USR = 2'd1,
    MAP_PTA = 2'd2,
    MAP_PTB = 2'd3
  } map_set_e;

  function automatic logic [IDX_W-1:0] f_index(input logic [SET_W-1:0] s,
                                              input logic [PG_W-1:0] pg);
    return {s, pg};
  endfunction

  function automatic logic [PA_W-1:0] f_phys(input logic [PPN_W-1:0] ppn,
                                            input logic [OFS_W-1:0] ofs);
    return {ppn, ofs};
  endfunction

  function automatic logic [ENT_W-1:0] f_viol_word(input logic [SET_W-1:0] s,
                                                  input logic [PG_W-1:0] pg,
                                                  input logic wr);
    logic [ENT_W-1:0] w;
    w = '0;
    w[ENT_W-1] = 1'b1;
    w[8] = wr;
    w[PG_W+SET_W-1:PG_W] = s;
    w[PG_W-1:0] = pg;
    return w;
  endfunction
endpackage

// File: rtl/pmap_regfile.sv
module pmap_regfile
  import pmap_pkg::*;
#(
  parameter int W = ENT_W,
  parameter int N = DEPTH,
  parameter int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ridx,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we) begin
      regs[widx] <= wdata;
    end
  end

  assign rdata = regs[ridx];
endmodule

// File: rtl/pmap_xlate.sv
module pmap_xlate
  import pmap_pkg::*;
(
  input  logic             map_en,
  input  logic             cur_user,
  input  logic             force_en,
  input  logic [SET_W-1:0] force_set,
  input  logic [LA_W-1:0]  log_addr,
  input  logic [ENT_W-1:0] entry,
  output logic [IDX_W-1:0] ridx,
  output logic [SET_W-1:0] act_set,
  output logic [PG_W-1:0]  page,
  output logic [PA_W-1:0]  phys_addr,
  output logic             rd_prot,
  output logic             wr_prot
);
  logic unused_rsvd;

  assign page    = log_addr[LA_W-1:OFS_W];
  assign act_set = force_en ? force_set : (cur_user ? MAP_USR : MAP_SYS);
  assign ridx    = f_index(act_set, page);

  always_comb begin
    if (map_en) phys_addr = f_phys(entry[PPN_W-1:0], log_addr[OFS_W-1:0]);
    else        phys_addr = {{(PA_W-LA_W){1'b0}}, log_addr};
  end

  assign rd_prot     = map_en & entry[RP_BIT];
  assign wr_prot     = map_en & entry[WP_BIT];
  assign unused_rsvd = ^entry[WP_BIT-1:PPN_W];
endmodule

// File: rtl/pmap_vcap.sv
module pmap_vcap
  import pmap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [SET_W-1:0] set_in,
  input  logic [PG_W-1:0]  page_in,
  input  logic             wr_in,
  output logic [ENT_W-1:0] viol_reg
);
  always_ff @(posedge clk) begin
    if (!rst_n)   viol_reg <= '0;
    else if (hit) viol_reg <= f_viol_word(set_in, page_in, wr_in);
  end
endmodule

// File: rtl/page_mapper.sv
module page_mapper
  import pmap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             map_en,
  input  logic             cur_user,
  input  logic             force_en,
  input  logic [SET_W-1:0] force_set,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [LA_W-1:0]  log_addr,
  output logic [PA_W-1:0]  phys_addr,
  output logic             viol,
  output logic [ENT_W-1:0] viol_reg,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [ENT_W-1:0] cfg_wdata
);
  logic [IDX_W-1:0] ridx;
  logic [ENT_W-1:0] entry;
  logic [SET_W-1:0] act_set;
  logic [PG_W-1:0]  page;
  logic             rd_prot, wr_prot;
  logic             hit_rd, hit_wr;

  pmap_regfile #(.W(ENT_W), .N(DEPTH), .AW(IDX_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .widx(cfg_idx), .wdata(cfg_wdata),
    .ridx(ridx), .rdata(entry)
  );

  pmap_xlate u_xl (
    .map_en(map_en), .cur_user(cur_user), .force_en(force_en),
    .force_set(force_set), .log_addr(log_addr), .entry(entry), .ridx(ridx),
    .act_set(act_set), .page(page), .phys_addr(phys_addr),
    .rd_prot(rd_prot), .wr_prot(wr_prot)
  );

  assign hit_rd = acc_valid & ~acc_write & rd_prot;
  assign hit_wr = acc_valid &  acc_write & wr_prot;
  assign viol   = hit_rd | hit_wr;

  pmap_vcap u_vc (
    .clk(clk), .rst_n(rst_n), .hit(viol), .set_in(act_set), .page_in(page),
    .wr_in(acc_write), .viol_reg(viol_reg)
  );
endmodule

// File: rtl/pmap_checker.sv
module pmap_checker
  import pmap_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             map_en,
  input logic             acc_valid,
  input logic             acc_write,
  input logic [LA_W-1:0]  log_addr,
  input logic [PA_W-1:0]  phys_addr,
  input logic             viol,
  input logic [ENT_W-1:0] viol_reg,
  input logic             hit_rd,
  input logic             hit_wr
);
  a_r3_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !map_en |-> phys_addr == {{(PA_W-LA_W){1'b0}}, log_addr});
  a_r3_no_viol_off: assert property (@(posedge clk) disable iff (!rst_n)
    !map_en |-> !viol);
  a_r4_offset: assert property (@(posedge clk) disable iff (!rst_n)
    map_en |-> phys_addr[OFS_W-1:0] == log_addr[OFS_W-1:0]);
  a_r7_r8_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_rd && hit_wr));
  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> viol_reg[ENT_W-1] && viol_reg[PG_W-1:0] == $past(log_addr[LA_W-1:OFS_W])
             && viol_reg[8] == $past(acc_write));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !viol |=> $stable(viol_reg));
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !viol);
endmodule

bind page_mapper pmap_checker u_chk (
  .clk(clk), .rst_n(rst_n), .map_en(map_en), .acc_valid(acc_valid),
  .acc_write(acc_write), .log_addr(log_addr), .phys_addr(phys_addr),
  .viol(viol), .viol_reg(viol_reg), .hit_rd(hit_rd), .hit_wr(hit_wr)
);

// File: tb/test_page_mapper.sv
module test_page_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        map_en = 1'b0, cur_user = 1'b0, force_en = 1'b0;
  logic [1:0]  force_set = 2'd0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [14:0] log_addr = '0;
  logic [19:0] phys_addr;
  logic        viol;
  logic [15:0] viol_reg;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_idx = '0;
  logic [15:0] cfg_wdata = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  page_mapper i_page_mapper (
    .clk(clk), .rst_n(rst_n), .map_en(map_en), .cur_user(cur_user),
    .force_en(force_en), .force_set(force_set), .acc_valid(acc_valid),
    .acc_write(acc_write), .log_addr(log_addr), .phys_addr(phys_addr),
    .viol(viol), .viol_reg(viol_reg), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata)
  );

  function automatic logic [9:0] ppn_of(input int idx);
    return 10'((idx * 37 + 5) % 1024);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_map(input int idx, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 7'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    done = 1'b1;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values
    chk("R1 viol_reg", 32'(viol_reg), 32'h0);
    chk("R1 viol", 32'(viol), 32'h0);
    map_en = 1'b1; log_addr = 15'h7abc; #1;
    chk("R1 zero map", 32'(phys_addr), 32'h002bc);

    // R2: load every map register
    for (int i = 0; i < 128; i++) wr_map(i, {6'b0, ppn_of(i)});

    // R2 R4 R6: forced sets, every page
    force_en = 1'b1;
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 32; p++) begin
        @(negedge clk);
        force_set = 2'(s); cur_user = p[0];
        log_addr = {5'(p), 10'((p * 53 + s * 7) % 1024)}; #1;
        chk("R6 R4 forced", 32'(phys_addr), 32'({ppn_of(s * 32 + p), log_addr[9:0]}));
      end
    end

    // R5: current-map select
    force_en = 1'b0;
    for (int u = 0; u < 2; u++) begin
      for (int p = 0; p < 32; p++) begin
        @(negedge clk);
        cur_user = u[0]; force_set = 2'd3;
        log_addr = {5'(p), 10'(1023 - p)}; #1;
        chk("R5 current map", 32'(phys_addr), 32'({ppn_of(u * 32 + p), log_addr[9:0]}));
      end
    end

    // R3: bypass
    map_en = 1'b0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      log_addr = 15'(k * 2047 + 3); #1;
      chk("R3 bypass", 32'(phys_addr), 32'(log_addr));
    end

    // R7: read-protect on port B page 7
    map_en = 1'b1;
    wr_map(3 * 32 + 7, 16'h8000 | 16'h0155);
    force_en = 1'b1; force_set = 2'd3; log_addr = {5'd7, 10'h012};
    acc_valid = 1'b1; acc_write = 1'b0; #1;
    chk("R7 read viol", 32'(viol), 32'h1);
    chk("R7 phys", 32'(phys_addr), 32'({10'h155, 10'h012}));
    @(negedge clk);
    chk("R9 capture read", 32'(viol_reg), 32'h8067);
    acc_write = 1'b1; #1;
    chk("R8 write allowed", 32'(viol), 32'h0);
    @(negedge clk);
    chk("R9 hold", 32'(viol_reg), 32'h8067);

    // R8: write-protect on user page 2
    wr_map(1 * 32 + 2, 16'h4000 | 16'h0099);
    force_en = 1'b0; cur_user = 1'b1; log_addr = {5'd2, 10'h3ff};
    acc_write = 1'b1; #1;
    chk("R8 write viol", 32'(viol), 32'h1);
    @(negedge clk);
    chk("R9 capture write", 32'(viol_reg), 32'h8122);
    acc_write = 1'b0; #1;
    chk("R7 read allowed", 32'(viol), 32'h0);
    @(negedge clk);
    chk("R9 hold after read", 32'(viol_reg), 32'h8122);

    // R10: no access, protected entry
    acc_valid = 1'b0; acc_write = 1'b1; #1;
    chk("R10 idle", 32'(viol), 32'h0);
    // R3: disabled, protected entry
    acc_valid = 1'b1; map_en = 1'b0; #1;
    chk("R3 no viol off", 32'(viol), 32'h0);
    chk("R3 phys off", 32'(phys_addr), 32'(log_addr));
    @(negedge clk);
    chk("R9 unchanged", 32'(viol_reg), 32'h8122);
    acc_valid = 1'b0;
    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule